// File: doc/BRIEF.md
# Setup-Mode Configuration Register Bank

This block holds the byte-wide configuration registers that a system board exposes during setup. The registers sit at bus offsets 2 through 5 and respond only while `setup_mode` is high. The stored bits become enable levels for the on-board floppy controller, the parallel port and the serial ports. Each device enable is gated by a single master bit. The block also decodes the parallel port's I/O address window from a two-bit select code, with a separate window used when the port runs DMA transfers. It drives the arbitration-level values used by the floppy and parallel-port DMA.

Offset 3 is an indexed status port. Software first writes an index, then reads the same offset. The read returns a byte chosen from live input pins: memory presence-detect nibbles, per-slot parity/ECC flags, or operator-panel information. The CPU interface is synchronous: a write takes effect at the clock edge where `wr_en` is sampled, and `rdata` is loaded at the clock edge where `rd_en` is sampled.

Top module: `setup_cfg_bank`

## Requirements
- R1: After reset, the bank reads as follows: offset 2 = 0x08, offset 4 = 0x02, offset 5 = 0x00, stored index = 0. Outputs after reset: every device enable is 0, the parallel port is bidirectional, floppy arbitration level is 2, burst is enabled, fairness is off, and the window is 0x03BC–0x03BF.
- R2: While `setup_mode` is 0, writes change nothing. A read while `setup_mode` is 0 loads 0xFF into `rdata` at the sampling edge. Reads in setup mode load the addressed byte into `rdata` at the sampling edge.
- R3: Offset 2 stores bits 7:4 and 1:0 of the written byte. On read, bit 3 is always 1 and bit 2 is always 0.
- R4: `serial_en` equals offset 2 bit 0 (the master enable). `fdd_en` is offset 2 bit 1 AND bit 0. `pport_en` is offset 2 bit 4 AND bit 0.
- R5: `pport_out_only` equals offset 2 bit 7: 1 means output-only, 0 means bidirectional.
- R6: The select code in offset 2 bits 6:5 gives the window {base, last}: 00 → 0x03BC–0x03BF, 01 → 0x0378–0x037D, 10 → 0x0278–0x027D, 11 → 0x1378–0x137D.
- R7: When `pport_dma` is 1 and the select code is 00, the window is 0x1278–0x127D. The other codes are unaffected by `pport_dma`.
- R8: A write to offset 3 with bit 0 = 1 stores bits 4:2 as the index. A write to offset 3 with bit 0 = 0 leaves the index unchanged. A read of offset 3 returns the status byte for the stored index.
- R9: Index n (0 to 3) returns connector slot n's B presence-detect nibble in bits 7:4 and its A nibble in bits 3:0. The A nibble for slot n comes from `pd_a[4n+3:4n]`, and the B nibble from `pd_b[4n+3:4n]`.
- R10: Index 4 returns the parity flags interleaved per slot: bit 2n = `par_a[n]` and bit 2n+1 = `par_b[n]` (1 = parity memory, 0 = ECC memory).
- R11: Index 7 returns {3'b000, `ua_status`, `panel_id[3:0]`}. Indexes 5 and 6 return 0xFF.
- R12: Offset 4 stores bits 5:0 and reads bits 7:6 as 0. `fdd_burst_en` is the inverse of bit 5, `fdd_fair_en` equals bit 4, and `fdd_arb` equals bits 3:0.
- R13: Offset 5 stores bits 3:0 into `pport_arb` and reads bits 7:4 as 0.
- R14: Offsets 0, 1, 6 and 7 read as 0xFF, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| setup_mode | input | 1 | Opens the bank to reads and writes |
| bus_addr | input | ADDR_W | Register offset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, loaded at the edge sampling rd_en |
| pd_a | input | 16 | Presence-detect nibbles, A connectors, slot n at [4n+3:4n] |
| pd_b | input | 16 | Presence-detect nibbles, B connectors |
| par_a | input | 4 | Parity(1)/ECC(0) flags, A connectors |
| par_b | input | 4 | Parity(1)/ECC(0) flags, B connectors |
| ua_status | input | 1 | Power-on source: 1 switch, 0 standby wake |
| panel_id | input | 4 | Operator panel identifier |
| pport_dma | input | 1 | Parallel port operates with DMA |
| serial_en | output | 1 | Serial ports enable (master) |
| fdd_en | output | 1 | Floppy controller enable |
| pport_en | output | 1 | Parallel port enable |
| pport_out_only | output | 1 | Parallel port output-only mode |
| pport_base | output | 16 | First I/O address of the port window |
| pport_last | output | 16 | Last I/O address of the port window |
| fdd_burst_en | output | 1 | Floppy burst transfers allowed |
| fdd_fair_en | output | 1 | Floppy fairness enabled |
| fdd_arb | output | 4 | Floppy arbitration level |
| pport_arb | output | 4 | Parallel-port arbitration level |

## Verification
Every stored bit reaches a port, either directly or through readback. A corrupted register therefore shows up in an enable level, an arbitration value or a window address immediately after the edge that wrote it. It also appears in `rdata` one edge after the next read. A wrong stored index is caught only by the next read of offset 3. For that reason the bench rewrites the index, and reads back after every index write and after every attempt that should leave the index alone. Gating errors involving `setup_mode` appear as either a changed output after a blocked write or a non-0xFF byte after a blocked read.

// File: rtl/setup_cfg_pkg.sv
package setup_cfg_pkg;
  localparam int SLOTS   = 4;
  localparam int PD_W    = 4;
  localparam int IDX_W   = 3;
  localparam int DATA_W  = 8;
  localparam int PORTA_W = 16;

  typedef struct packed {
    logic       out_only;
    logic [1:0] sel;
    logic       pp_on;
    logic       fdd_on;
    logic       master;
  } portctl_t;

  typedef struct packed {
    logic       burst_off;
    logic       fair_on;
    logic [3:0] arb;
  } fddctl_t;

  // Readback image of the port-control register: fixed 1 at bit 3, 0 at bit 2.
  function automatic logic [DATA_W-1:0] portctl_byte(input portctl_t p);
    return {p.out_only, p.sel, p.pp_on, 1'b1, 1'b0, p.fdd_on, p.master};
  endfunction

  // Returns {base, last} of the parallel port I/O window.
  function automatic logic [2*PORTA_W-1:0] pport_window(input logic [1:0] sel,
                                                       input logic dma);
    logic [2*PORTA_W-1:0] w;
    case (sel)
      2'b00:   w = dma ? {16'h1278, 16'h127D} : {16'h03BC, 16'h03BF};
      2'b01:   w = {16'h0378, 16'h037D};
      2'b10:   w = {16'h0278, 16'h027D};
      default: w = {16'h1378, 16'h137D};
    endcase
    return w;
  endfunction
endpackage

// File: rtl/setup_cfg_regs.sv
module setup_cfg_regs
  import setup_cfg_pkg::*;
#(
  parameter int FDD_ARB_RESET = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_ctl,
  input  logic                 wr_idx,
  input  logic                 wr_fdd,
  input  logic                 wr_pp,
  input  logic [DATA_W-1:0]    wdata,
  output portctl_t             ctl,
  output logic [IDX_W-1:0]     idx,
  output fddctl_t              fdd,
  output logic [3:0]           pp_arb
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl    <= '0;
      idx    <= '0;
      fdd    <= '{burst_off: 1'b0, fair_on: 1'b0, arb: 4'(FDD_ARB_RESET)};
      pp_arb <= '0;
    end else begin
      if (wr_ctl)
        ctl <= '{out_only: wdata[7], sel: wdata[6:5], pp_on: wdata[4],
                 fdd_on: wdata[1], master: wdata[0]};
      if (wr_idx && wdata[0])
        idx <= wdata[4:2];
      if (wr_fdd)
        fdd <= '{burst_off: wdata[5], fair_on: wdata[4], arb: wdata[3:0]};
      if (wr_pp)
        pp_arb <= wdata[3:0];
    end
  end
endmodule

// File: rtl/setup_cfg_status_mux.sv
module setup_cfg_status_mux
  import setup_cfg_pkg::*;
(
  input  logic [IDX_W-1:0]      idx,
  input  logic [SLOTS*PD_W-1:0] pd_a,
  input  logic [SLOTS*PD_W-1:0] pd_b,
  input  logic [SLOTS-1:0]      par_a,
  input  logic [SLOTS-1:0]      par_b,
  input  logic                  ua_status,
  input  logic [3:0]            panel_id,
  output logic [DATA_W-1:0]     status
);
  logic [2*SLOTS-1:0] par_byte;

  for (genvar k = 0; k < SLOTS; k++) begin : g_par
    assign par_byte[2*k]   = par_a[k];
    assign par_byte[2*k+1] = par_b[k];
  end

  always_comb begin
    case (idx)
      3'd0, 3'd1, 3'd2, 3'd3:
        status = {pd_b[{idx[1:0], 2'b00} +: PD_W], pd_a[{idx[1:0], 2'b00} +: PD_W]};
      3'd4:    status = par_byte;
      3'd7:    status = {3'b000, ua_status, panel_id};
      default: status = 8'hFF;
    endcase
  end
endmodule

// File: rtl/setup_cfg_window.sv
module setup_cfg_window
  import setup_cfg_pkg::*;
(
  input  logic [1:0]         sel,
  input  logic               dma,
  output logic [PORTA_W-1:0] base,
  output logic [PORTA_W-1:0] last
);
  assign {base, last} = pport_window(sel, dma);
endmodule

// File: rtl/setup_cfg_bank.sv
module setup_cfg_bank
  import setup_cfg_pkg::*;
#(
  parameter int ADDR_W        = 3,
  parameter int FDD_ARB_RESET = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  setup_mode,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic                  wr_en,
  input  logic                  rd_en,
  input  logic [7:0]            wdata,
  output logic [7:0]            rdata,
  input  logic [15:0]           pd_a,
  input  logic [15:0]           pd_b,
  input  logic [3:0]            par_a,
  input  logic [3:0]            par_b,
  input  logic                  ua_status,
  input  logic [3:0]            panel_id,
  input  logic                  pport_dma,
  output logic                  serial_en,
  output logic                  fdd_en,
  output logic                  pport_en,
  output logic                  pport_out_only,
  output logic [15:0]           pport_base,
  output logic [15:0]           pport_last,
  output logic                  fdd_burst_en,
  output logic                  fdd_fair_en,
  output logic [3:0]            fdd_arb,
  output logic [3:0]            pport_arb
);
  // Named internal events, visible to the bound checker.
  logic wr_accept, rd_accept;
  logic hit_ctl, hit_idx, hit_fdd, hit_pp;

  portctl_t          ctl;
  fddctl_t           fdd;
  logic [IDX_W-1:0]  idx;
  logic [3:0]        pp_arb_q;
  logic [DATA_W-1:0] status_byte;
  logic [DATA_W-1:0] rd_value;

  assign wr_accept = wr_en && setup_mode;
  assign rd_accept = rd_en && setup_mode;
  assign hit_ctl   = (bus_addr == ADDR_W'(2));
  assign hit_idx   = (bus_addr == ADDR_W'(3));
  assign hit_fdd   = (bus_addr == ADDR_W'(4));
  assign hit_pp    = (bus_addr == ADDR_W'(5));

  setup_cfg_regs #(.FDD_ARB_RESET(FDD_ARB_RESET)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_ctl (wr_accept && hit_ctl),
    .wr_idx (wr_accept && hit_idx),
    .wr_fdd (wr_accept && hit_fdd),
    .wr_pp  (wr_accept && hit_pp),
    .wdata  (wdata),
    .ctl    (ctl),
    .idx    (idx),
    .fdd    (fdd),
    .pp_arb (pp_arb_q)
  );

  setup_cfg_status_mux u_status (
    .idx       (idx),
    .pd_a      (pd_a),
    .pd_b      (pd_b),
    .par_a     (par_a),
    .par_b     (par_b),
    .ua_status (ua_status),
    .panel_id  (panel_id),
    .status    (status_byte)
  );

  setup_cfg_window u_window (
    .sel  (ctl.sel),
    .dma  (pport_dma),
    .base (pport_base),
    .last (pport_last)
  );

  always_comb begin
    if (!setup_mode)   rd_value = 8'hFF;
    else if (hit_ctl)  rd_value = portctl_byte(ctl);
    else if (hit_idx)  rd_value = status_byte;
    else if (hit_fdd)  rd_value = {2'b00, fdd};
    else if (hit_pp)   rd_value = {4'h0, pp_arb_q};
    else               rd_value = 8'hFF;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= rd_value;
  end

  assign serial_en      = ctl.master;
  assign fdd_en         = ctl.fdd_on & ctl.master;
  assign pport_en       = ctl.pp_on & ctl.master;
  assign pport_out_only = ctl.out_only;
  assign fdd_burst_en   = ~fdd.burst_off;
  assign fdd_fair_en    = fdd.fair_on;
  assign fdd_arb        = fdd.arb;
  assign pport_arb      = pp_arb_q;
endmodule

// File: rtl/setup_cfg_bank_chk.sv
module setup_cfg_bank_chk #(
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              setup_mode,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              wr_en,
  input logic              rd_en,
  input logic [7:0]        wdata,
  input logic [7:0]        rdata,
  input logic              wr_accept,
  input logic              rd_accept,
  input logic              serial_en,
  input logic              fdd_en,
  input logic              pport_en,
  input logic              pport_out_only,
  input logic [15:0]       pport_base,
  input logic [15:0]       pport_last,
  input logic              fdd_burst_en,
  input logic [3:0]        fdd_arb,
  input logic [3:0]        pport_arb
);
  assert_gate_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !setup_mode) |=> ($stable(fdd_arb) && $stable(pport_arb) &&
                                $stable(serial_en) && $stable(pport_out_only)));

  assert_gate_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !setup_mode) |=> (rdata == 8'hFF));

  assert_fixed_bits_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_accept && bus_addr == ADDR_W'(2)) |=> (rdata[3:2] == 2'b10));

  assert_master_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_accept && bus_addr == ADDR_W'(2) && !wdata[0]) |=> (!fdd_en && !pport_en && !serial_en));

  assert_needs_master_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fdd_en || pport_en) |-> serial_en);

  assert_window_span_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((pport_last - pport_base) == 16'd3) || ((pport_last - pport_base) == 16'd5));

  assert_fdd_write_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_accept && bus_addr == ADDR_W'(4)) |=>
      (fdd_arb == $past(wdata[3:0]) && fdd_burst_en == !$past(wdata[5])));

  assert_pp_write_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_accept && bus_addr == ADDR_W'(5)) |=> (pport_arb == $past(wdata[3:0])));
endmodule

bind setup_cfg_bank setup_cfg_bank_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .setup_mode(setup_mode), .bus_addr(bus_addr),
  .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata), .rdata(rdata),
  .wr_accept(wr_accept), .rd_accept(rd_accept), .serial_en(serial_en),
  .fdd_en(fdd_en), .pport_en(pport_en), .pport_out_only(pport_out_only),
  .pport_base(pport_base), .pport_last(pport_last), .fdd_burst_en(fdd_burst_en),
  .fdd_arb(fdd_arb), .pport_arb(pport_arb)
);

// File: tb/setup_cfg_bank_bench.sv
module setup_cfg_bank_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        setup_mode = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [15:0] pd_a = 16'hC3A5, pd_b = 16'h96E1;
  logic [3:0]  par_a = 4'b0101, par_b = 4'b0011;
  logic        ua_status = 1'b1;
  logic [3:0]  panel_id = 4'hB;
  logic        pport_dma = 1'b0;
  logic        serial_en, fdd_en, pport_en, pport_out_only;
  logic [15:0] pport_base, pport_last;
  logic        fdd_burst_en, fdd_fair_en;
  logic [3:0]  fdd_arb, pport_arb;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  setup_cfg_bank u_setup_cfg_bank (
    .clk(clk), .rst_n(rst_n), .setup_mode(setup_mode), .bus_addr(bus_addr),
    .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata), .rdata(rdata),
    .pd_a(pd_a), .pd_b(pd_b), .par_a(par_a), .par_b(par_b),
    .ua_status(ua_status), .panel_id(panel_id), .pport_dma(pport_dma),
    .serial_en(serial_en), .fdd_en(fdd_en), .pport_en(pport_en),
    .pport_out_only(pport_out_only), .pport_base(pport_base), .pport_last(pport_last),
    .fdd_burst_en(fdd_burst_en), .fdd_fair_en(fdd_fair_en),
    .fdd_arb(fdd_arb), .pport_arb(pport_arb)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic test_reset();
    logic [7:0] d;
    check("R1 serial_en", serial_en, 0);
    check("R1 fdd_en", fdd_en, 0);
    check("R1 pport_en", pport_en, 0);
    check("R1 out_only", pport_out_only, 0);
    check("R1 fdd_arb", fdd_arb, 2);
    check("R1 burst", fdd_burst_en, 1);
    check("R1 fair", fdd_fair_en, 0);
    check("R1 window", {pport_base, pport_last}, 32'h03BC03BF);
    rd(3'd2, d); check("R1 off2", d, 8'h08);
    rd(3'd3, d); check("R1 idx0", d, 8'h15);
    rd(3'd4, d); check("R1 off4", d, 8'h02);
    rd(3'd5, d); check("R1 off5", d, 8'h00);
  endtask

  task automatic test_gate();
    logic [7:0] d;
    setup_mode = 1'b0;
    wr(3'd5, 8'h07);
    wr(3'd2, 8'h13);
    check("R2 blocked pp arb", pport_arb, 0);
    check("R2 blocked master", serial_en, 0);
    rd(3'd5, d); check("R2 blocked read", d, 8'hFF);
    setup_mode = 1'b1;
    rd(3'd5, d); check("R2 setup read", d, 8'h00);
  endtask

  task automatic test_ctl_readback();
    logic [7:0] d;
    wr(3'd2, 8'hFF); rd(3'd2, d); check("R3 all ones", d, 8'hFB);
    wr(3'd2, 8'h00); rd(3'd2, d); check("R3 all zeros", d, 8'h08);
    wr(3'd2, 8'hA6); rd(3'd2, d); check("R3 mixed", d, 8'hAA);
  endtask

  task automatic test_master();
    wr(3'd2, 8'h13); check("R4 all on", {serial_en, fdd_en, pport_en}, 3'b111);
    wr(3'd2, 8'h12); check("R4 master off", {serial_en, fdd_en, pport_en}, 3'b000);
    wr(3'd2, 8'h03); check("R4 fdd only", {serial_en, fdd_en, pport_en}, 3'b110);
    wr(3'd2, 8'h11); check("R4 pp only", {serial_en, fdd_en, pport_en}, 3'b101);
    wr(3'd2, 8'h81); check("R5 output only", pport_out_only, 1);
    wr(3'd2, 8'h01); check("R5 bidirectional", pport_out_only, 0);
  endtask

  task automatic test_windows();
    logic [31:0] exp;
    for (int dm = 0; dm < 2; dm++) begin
      pport_dma = dm[0];
      for (int s = 0; s < 4; s++) begin
        wr(3'd2, {1'b0, s[1:0], 5'b00001});
        case (s)
          0: exp = dm[0] ? 32'h1278127D : 32'h03BC03BF;
          1: exp = 32'h0378037D;
          2: exp = 32'h0278027D;
          default: exp = 32'h1378137D;
        endcase
        check(dm[0] ? "R7 dma window" : "R6 window", {pport_base, pport_last}, exp);
      end
    end
    pport_dma = 1'b0;
  endtask

  task automatic test_index();
    logic [7:0] d;
    logic [7:0] exp_pd [4] = '{8'h15, 8'hEA, 8'h63, 8'h9C};
    for (int i = 0; i < 4; i++) begin
      wr(3'd3, {3'b000, i[2:0], 2'b01}); rd(3'd3, d);
      check("R9 presence", d, exp_pd[i]);
    end
    wr(3'd3, 8'h05); wr(3'd3, 8'h0C); rd(3'd3, d);
    check("R8 bit0 clear keeps index", d, 8'hEA);
    wr(3'd3, 8'h11); rd(3'd3, d); check("R10 parity A", d, 8'h1B);
    par_a = 4'b1010; par_b = 4'b0100; rd(3'd3, d);
    check("R10 parity B", d, 8'h64);
    wr(3'd3, 8'h1D); rd(3'd3, d); check("R11 panel A", d, 8'h1B);
    ua_status = 1'b0; panel_id = 4'h5; rd(3'd3, d);
    check("R11 panel B", d, 8'h05);
    wr(3'd3, 8'h15); rd(3'd3, d); check("R11 index5", d, 8'hFF);
    wr(3'd3, 8'h19); rd(3'd3, d); check("R11 index6", d, 8'hFF);
  endtask

  task automatic test_arb();
    logic [7:0] d;
    wr(3'd4, 8'h3F); rd(3'd4, d); check("R12 read", d, 8'h3F);
    check("R12 fields", {fdd_burst_en, fdd_fair_en, fdd_arb}, 6'b0_1_1111);
    wr(3'd4, 8'hE5); rd(3'd4, d); check("R12 upper zero", d, 8'h25);
    check("R12 fields2", {fdd_burst_en, fdd_fair_en, fdd_arb}, 6'b0_0_0101);
    wr(3'd4, 8'h12);
    check("R12 fields3", {fdd_burst_en, fdd_fair_en, fdd_arb}, 6'b1_1_0010);
    wr(3'd5, 8'hA9); rd(3'd5, d); check("R13 read", d, 8'h09);
    check("R13 pport_arb", pport_arb, 4'h9);
  endtask

  task automatic test_unmapped();
    logic [7:0] d;
    wr(3'd2, 8'h13);
    wr(3'd0, 8'h00); wr(3'd1, 8'h00); wr(3'd6, 8'h00); wr(3'd7, 8'h00);
    rd(3'd2, d); check("R14 off2 untouched", d, 8'h1B);
    rd(3'd4, d); check("R14 off4 untouched", d, 8'h12);
    rd(3'd5, d); check("R14 off5 untouched", d, 8'h09);
    rd(3'd0, d); check("R14 off0", d, 8'hFF);
    rd(3'd1, d); check("R14 off1", d, 8'hFF);
    rd(3'd6, d); check("R14 off6", d, 8'hFF);
    rd(3'd7, d); check("R14 off7", d, 8'hFF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    setup_mode = 1'b1;
    @(negedge clk);
    test_reset();
    test_gate();
    test_ctl_readback();
    test_master();
    test_windows();
    test_index();
    test_arb();
    test_unmapped();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule